// File: doc/BRIEF.md
# Keyboard and Display Handshake Port

This block connects a processor bus to an ASCII keyboard and to a character display through four byte-wide registers, selected by a 2-bit offset. The keyboard delivers a 7-bit key code together with a strobe. The display takes a 7-bit character and reports whether it can accept another one. Software polls two status bits and never receives an interrupt.

Both asynchronous inputs, the keyboard strobe and the display ready line, pass through a two-flop synchronizer before the port uses them. A rising edge of the synchronized strobe latches the key code and raises a sticky key-ready flag. Software clears the flag by reading the key register. A write to the display character register updates the 7-bit display output and pulses a one-cycle write strobe. The same register, when read, returns the display ready state in its top bit.

Read data is combinational from the offset, so it is valid in the cycle the offset is presented. The clear that goes with a key read takes effect on the clock edge at the end of that cycle. The keyboard is assumed to hold its code stable from the strobe's rising edge until at least three clock edges later.

Top module: `kbd_disp_port`

## Requirements
- R1: After reset the key-ready flag is 0, the latched key code is 0, the display output is 0 and the display write strobe is 0.
- R2: A read at offset 0 returns bit 7 as 1 and the latched 7-bit key code in bits 6:0.
- R3: A rising edge of the keyboard strobe sets the key-ready flag. The flag reads back in bit 7 of offset 1, and bits 6:0 of offset 1 read as 0. The flag first reads as 1 after the third rising clock edge following the strobe's rise.
- R4: A read strobe at offset 0 clears the key-ready flag on that clock edge. A read at offset 1 leaves the flag unchanged.
- R5: The key code is captured on the same edge that sets the flag. Later changes of the code input, without a new strobe edge, do not change what offset 0 returns.
- R6: When a strobe edge and an offset-0 read fall in the same clock cycle, the flag stays set and the new code is latched.
- R7: A write at offset 2 drives bits 6:0 of the write data onto the display output from the next edge onward. It also raises the display write strobe for exactly one cycle.
- R8: A read at offset 2 returns the synchronized display ready input in bit 7, where 1 means ready and 0 means busy, and the last written character in bits 6:0. A change of the ready input is visible after two clock edges.
- R9: Offset 3 reads as 0. Writes at offsets 0, 1 and 3 leave the display output, the write strobe and the key-ready flag unchanged.
- R10: A strobe that stays high after its flag has been cleared does not set the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_rd_en | input | 1 | Read strobe; enables the offset-0 side effect |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| kbd_code | input | 7 | Key code from the keyboard |
| kbd_strobe | input | 1 | Key strobe, asynchronous |
| disp_ready | input | 1 | Display ready (1) or busy (0), asynchronous |
| disp_data | output | 7 | Character to the display |
| disp_wr_strobe | output | 1 | One-cycle pulse after a display write |

## Verification
The hardest case to reach is the collision between a strobe edge and a read of the key register. The synchronizer hides the exact cycle of the edge, so an arbitrary read almost never lands on it. The stimulus therefore raises the strobe on a falling clock edge and counts two rising edges. It then holds the offset-0 read across the third rising edge, which is the one where the flag is set, and checks that both the flag and the new code survive.

// File: rtl/kdp_pkg.sv
// Shared definitions for the keyboard/display handshake port.
// Assumes a byte-wide bus whose top bit is used as a status bit.
package kdp_pkg;
    localparam int KDP_ADDR_W = 2;

    // Register offsets; software depends on this numbering.
    typedef enum logic [KDP_ADDR_W-1:0] {
        OFS_KEY_DATA  = 2'd0,
        OFS_KEY_STAT  = 2'd1,
        OFS_DSP_DATA  = 2'd2,
        OFS_DSP_CTRL  = 2'd3
    } kdp_ofs_e;
endpackage

// File: rtl/kdp_sync.sv
// Multi-flop synchronizer for single-bit asynchronous inputs.
// Assumes each input is a level that stays stable for longer than STAGES clocks.
module kdp_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/kdp_key_side.sv
// Keyboard half: detects the rising edge of the synchronized strobe, latches
// the key code and keeps a sticky ready flag that a data read clears.
// Assumes the code input is stable while the synchronized edge is detected.
module kdp_key_side #(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_s,
    input  logic [CODE_W-1:0] code_in,
    input  logic              rd_clr,
    output logic              key_flag,
    output logic [CODE_W-1:0] key_code
);
    logic strobe_prev_q;
    logic strobe_rise;

    // Remember the previous synchronized strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_prev_q <= 1'b0;
        else        strobe_prev_q <= strobe_s;
    end

    assign strobe_rise = strobe_s & ~strobe_prev_q;

    // Set on a new edge (which wins over a clear), clear on a data read.
    always_ff @(posedge clk) begin
        if (!rst_n)           key_flag <= 1'b0;
        else if (strobe_rise) key_flag <= 1'b1;
        else if (rd_clr)      key_flag <= 1'b0;
    end

    // Capture the code on the same edge that raises the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)           key_code <= '0;
        else if (strobe_rise) key_code <= code_in;
    end

    AST_FLAG_SET_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_rise |=> key_flag); // R3
    AST_FLAG_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !strobe_rise) |=> !key_flag); // R4
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_rise |=> $stable(key_code)); // R5
    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_rise && rd_clr) |=> (key_flag && key_code == $past(code_in))); // R6
    AST_NO_RESET_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_s && strobe_prev_q && !key_flag) |=> !key_flag); // R10
endmodule

// File: rtl/kdp_dsp_side.sv
// Display half: holds the last written character and pulses a write strobe
// for one cycle after each write.
// Assumes the display samples its data while the write strobe is high.
module kdp_dsp_side #(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [CODE_W-1:0] wr_char,
    output logic [CODE_W-1:0] char_q,
    output logic              char_stb
);
    // Load the character on a display write.
    always_ff @(posedge clk) begin
        if (!rst_n)      char_q <= '0;
        else if (wr_hit) char_q <= wr_char;
    end

    // Produce a one-cycle strobe that follows each write.
    always_ff @(posedge clk) begin
        if (!rst_n) char_stb <= 1'b0;
        else        char_stb <= wr_hit;
    end

    AST_STB_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (char_stb && char_q == $past(wr_char))); // R7
    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> !char_stb); // R7
    AST_CHAR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(char_q)); // R9
endmodule

// File: rtl/kbd_disp_port.sv
// Top of the keyboard/display handshake port: four-register bus decode,
// input synchronizers and the two peripheral halves.
// Assumes a single-cycle bus: read data is valid in the cycle the offset is
// presented, and side effects take place on the clock edge that ends it.
module kbd_disp_port
    import kdp_pkg::*;
#(
    parameter int CODE_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [KDP_ADDR_W-1:0] bus_addr,
    input  logic                  bus_rd_en,
    input  logic                  bus_wr_en,
    input  logic [CODE_W:0]       bus_wdata,
    output logic [CODE_W:0]       bus_rdata,
    input  logic [CODE_W-1:0]     kbd_code,
    input  logic                  kbd_strobe,
    input  logic                  disp_ready,
    output logic [CODE_W-1:0]     disp_data,
    output logic                  disp_wr_strobe
);
    localparam int DATA_W = CODE_W + 1;

    logic              strobe_s;
    logic              ready_s;
    logic              key_flag;
    logic [CODE_W-1:0] key_code;
    logic              key_rd_clr;
    logic              dsp_wr_hit;
    logic              unused_wtop;

    assign unused_wtop = bus_wdata[DATA_W-1];

    kdp_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_sync_strobe (
        .clk(clk), .rst_n(rst_n), .async_in(kbd_strobe), .sync_out(strobe_s)
    );

    kdp_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_sync_ready (
        .clk(clk), .rst_n(rst_n), .async_in(disp_ready), .sync_out(ready_s)
    );

    // Bus strobes that reach the two halves.
    assign key_rd_clr = bus_rd_en && (bus_addr == OFS_KEY_DATA);
    assign dsp_wr_hit = bus_wr_en && (bus_addr == OFS_DSP_DATA);

    kdp_key_side #(.CODE_W(CODE_W)) u_key (
        .clk(clk), .rst_n(rst_n), .strobe_s(strobe_s), .code_in(kbd_code),
        .rd_clr(key_rd_clr), .key_flag(key_flag), .key_code(key_code)
    );

    kdp_dsp_side #(.CODE_W(CODE_W)) u_dsp (
        .clk(clk), .rst_n(rst_n), .wr_hit(dsp_wr_hit),
        .wr_char(bus_wdata[CODE_W-1:0]),
        .char_q(disp_data), .char_stb(disp_wr_strobe)
    );

    // Read multiplexer selected by the register offset.
    always_comb begin
        unique case (bus_addr)
            OFS_KEY_DATA: bus_rdata = {1'b1, key_code};
            OFS_KEY_STAT: bus_rdata = {key_flag, {CODE_W{1'b0}}};
            OFS_DSP_DATA: bus_rdata = {ready_s, disp_data};
            default:      bus_rdata = '0;
        endcase
    end

    AST_KEY_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_KEY_DATA) |-> bus_rdata[DATA_W-1]); // R2
    AST_READY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_DSP_DATA && $past(ready_s) == ready_s)
        |-> bus_rdata[DATA_W-1] == ready_s); // R8
    AST_FOREIGN_WRITE_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr != OFS_DSP_DATA) |=> !disp_wr_strobe); // R9
endmodule

// File: tb/kbd_disp_port_tb_top.sv
`timescale 1ns/1ps
module kbd_disp_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_rd_en = 1'b0;
    logic       bus_wr_en = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [6:0] kbd_code = 7'd0;
    logic       kbd_strobe = 1'b0;
    logic       disp_ready = 1'b0;
    logic [6:0] disp_data;
    logic       disp_wr_strobe;

    typedef struct {
        int         src;
        logic [7:0] exp;
        string      tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    kbd_disp_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd_en(bus_rd_en),
        .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kbd_code(kbd_code), .kbd_strobe(kbd_strobe), .disp_ready(disp_ready),
        .disp_data(disp_data), .disp_wr_strobe(disp_wr_strobe)
    );

    // Monitor: pop each expected item and compare against the named output.
    initial begin
        forever begin
            exp_item_t it;
            logic [7:0] act;
            wait (exp_q.size() > 0);
            it = exp_q.pop_front();
            case (it.src)
                0:       act = bus_rdata;
                1:       act = {1'b0, disp_data};
                default: act = {7'd0, disp_wr_strobe};
            endcase
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
            end
        end
    end

    // Push an expectation a little after the falling edge (src 0 rdata, 1 data, 2 strobe).
    task automatic expect_out(input int src, input logic [7:0] exp, input string tag);
        #1;
        exp_q.push_back('{src: src, exp: exp, tag: tag});
        #0;
    endtask

    task automatic peek(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b0; bus_wr_en = 1'b0;
        expect_out(0, exp, tag);
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1; bus_wr_en = 1'b0;
        expect_out(0, exp, tag);
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1; bus_rd_en = 1'b0;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press(input logic [6:0] code);
        @(negedge clk);
        kbd_code = code; kbd_strobe = 1'b1;
        wait_cyc(4);
        kbd_strobe = 1'b0;
        wait_cyc(3);
    endtask

    task automatic finish_run();
        wait (exp_q.size() == 0);
        #1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;

        // R1 reset state
        peek(2'd1, 8'h00, "R1 flag after reset");
        expect_out(1, 8'h00, "R1 display output after reset");
        expect_out(2, 8'h00, "R1 write strobe after reset");
        peek(2'd0, 8'h80, "R1 R2 code after reset");

        // R3: flag latency through synchronizer and edge detector
        @(negedge clk);
        kbd_code = 7'h41; kbd_strobe = 1'b1;
        peek(2'd1, 8'h00, "R3 flag low after one edge");
        peek(2'd1, 8'h00, "R3 flag low after two edges");
        peek(2'd1, 8'h80, "R3 flag high after third edge");
        peek(2'd0, 8'hC1, "R2 key data readback");

        // R5: code change without new edge
        @(negedge clk);
        kbd_code = 7'h22;
        wait_cyc(2);
        peek(2'd0, 8'hC1, "R5 code held without edge");

        // R4: control read keeps flag, data read clears it
        rd_chk(2'd1, 8'h80, "R4 control read");
        peek(2'd1, 8'h80, "R4 flag kept after control read");
        rd_chk(2'd0, 8'hC1, "R4 data read");
        peek(2'd1, 8'h00, "R4 flag cleared by data read");

        // R10: held strobe does not set the flag again
        wait_cyc(4);
        peek(2'd1, 8'h00, "R10 held strobe no re-set");
        @(negedge clk);
        kbd_strobe = 1'b0;
        wait_cyc(3);

        press(7'h5A);
        peek(2'd1, 8'h80, "R3 second key flag");
        peek(2'd0, 8'hDA, "R5 second code latched");
        rd_chk(2'd0, 8'hDA, "R4 clear second key");

        // R6: edge and data read in the same cycle
        @(negedge clk);
        kbd_code = 7'h33; kbd_strobe = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 2'd0; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        bus_addr = 2'd1;
        expect_out(0, 8'h80, "R6 flag survives collision");
        peek(2'd0, 8'hB3, "R6 new code latched in collision");
        @(negedge clk);
        kbd_strobe = 1'b0;
        rd_chk(2'd0, 8'hB3, "R6 read after collision");
        peek(2'd1, 8'h00, "R4 flag cleared after collision");

        // R7: display writes
        @(negedge clk);
        bus_addr = 2'd2; bus_wdata = 8'hFF; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        expect_out(1, 8'h7F, "R7 low seven bits driven");
        expect_out(2, 8'h01, "R7 strobe high after write");
        @(negedge clk);
        expect_out(2, 8'h00, "R7 strobe lasts one cycle");
        bus_wr(2'd2, 8'h15);
        expect_out(1, 8'h15, "R7 second character");

        // R8: ready readback through synchronizer
        peek(2'd2, 8'h15, "R8 busy reads zero top bit");
        @(negedge clk);
        disp_ready = 1'b1;
        peek(2'd2, 8'h15, "R8 ready not yet visible");
        peek(2'd2, 8'h95, "R8 ready visible after two edges");

        // R9: writes elsewhere do not touch display or flag
        bus_wr(2'd3, 8'h7F);
        expect_out(2, 8'h00, "R9 no strobe on offset 3 write");
        bus_wr(2'd0, 8'h11);
        expect_out(2, 8'h00, "R9 no strobe on offset 0 write");
        bus_wr(2'd1, 8'hA2);
        expect_out(1, 8'h15, "R9 display unchanged");
        peek(2'd1, 8'h00, "R9 flag unchanged by writes");
        peek(2'd3, 8'h00, "R9 offset 3 reads zero");

        wait_cyc(2);
        finished = 1;
        finish_run();
    end
endmodule